// File: doc/BRIEF.md
# Dual-mode 8-bit timer/counter

This block is a compact timer/counter with two ways of working. In reload mode the low byte counts up. When it rolls over from all ones it sets the low overflow flag and, in that same clock, takes its next value from the high byte. The high byte is never touched by the reload, so software may change it at any time and the next rollover uses the new value. In split mode the two bytes run as separate 8-bit timers. The low byte keeps its own source select, gate and run bit and its own flag, and it wraps to zero. The high byte always counts the prescaled clock, is run by a second run bit and sets the high overflow flag.

The count source for the low byte is either the system clock divided by six or falling edges on an external count pin. Both external pins pass through two synchronising flops. Counting of the low byte can be gated by an external pin. Each overflow flag drives an interrupt request, and an acknowledge input clears the flag. Software reaches the mode, control, low and high registers through a single-cycle write port. The two counter bytes can be read back on output ports.

Top module: `dual8_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both bytes, both flags, the mode and run bits and the prescaler. After reset no counting happens until software sets a run bit.
- R2: In timer source (mode bit 2 = 0), with the low run bit (control bit 4) set and gating off, the low byte advances exactly once in every 6 consecutive clock edges.
- R3: In reload mode (mode field bits[1:0] not equal to 3), a low-byte step from 0xFF loads the high byte into the low byte, sets `flag_lo`, and leaves the high byte unchanged.
- R4: A value written to the high byte (`wr_sel`=3) is the value loaded at the next reload.
- R5: `ack_lo`/`ack_hi` clears the matching flag on the next edge. An overflow in the same cycle as the acknowledge leaves the flag set.
- R6: In counter source (mode bit 2 = 1), the low byte advances once per falling edge of `cnt_pin`. The pin passes through a two-flop synchroniser, so the count is visible 3 edges after the pin falls. Rising edges and a steady pin do not count.
- R7: With the gate bit (mode bit 3) set, the low byte does not count while `gate_pin` (two-flop synchronised) is low, and it counts normally while the pin is high.
- R8: A software write to the low byte (`wr_sel`=2) in the same cycle as a reload wins: the low byte takes the written value, and `flag_lo` is still set.
- R9: In split mode (mode field = 3), the low byte wraps 0xFF to 0x00 and sets `flag_lo`. The high byte advances once every 6 edges while the high run bit (control bit 6) is set, ignoring the source and gate bits, and its wrap from 0xFF sets `flag_hi`.
- R10: `irq_lo` and `irq_hi` are high exactly while `flag_lo` and `flag_hi` are high.
- R11: With the low run bit clear, the low byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_pin | input | 1 | External count pin; falling edges count in counter source |
| gate_pin | input | 1 | External gate pin; low holds the low byte when the gate bit is set |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 control, 2 low byte, 3 high byte |
| wr_data | input | W | Write data. Mode: bits[1:0] mode field, bit 2 source, bit 3 gate. Control: bit 4 low run, bit 6 high run |
| ack_lo | input | 1 | Interrupt acknowledge for the low flag |
| ack_hi | input | 1 | Interrupt acknowledge for the high flag |
| lo_q | output | W | Low byte value |
| hi_q | output | W | High byte value |
| flag_lo | output | 1 | Low overflow flag |
| flag_hi | output | 1 | High overflow flag |
| irq_lo | output | 1 | Low interrupt request |
| irq_hi | output | 1 | High interrupt request |

## Verification
Two events can land on the same edge: a reload from the high byte and a software write to the low byte, and likewise an overflow and the acknowledge of its flag. The bench provokes both collisions on purpose. It tracks the prescaler phase in its own model and starts the counter so that the write or the acknowledge falls exactly on the edge where the low byte leaves 0xFF. It then requires the written value to win and the flag to stay set. Random traffic makes further collisions by chance, and every cycle is compared against the bench model.

// File: rtl/dual8_timer.sv
module dual8_timer #(
  parameter int W        = 8,
  parameter int PRESCALE = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_pin,
  input  logic         gate_pin,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ack_lo,
  input  logic         ack_hi,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         flag_lo,
  output logic         flag_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
  localparam logic [1:0] SEL_MODE = 2'd0, SEL_CTRL = 2'd1, SEL_LO = 2'd2, SEL_HI = 2'd3;

  logic [1:0]    mode_q;
  logic          ct_q, gate_q, run0_q, run1_q;
  logic [PW-1:0] pre_q;
  logic [2:0]    pin_s;
  logic [1:0]    gate_s;

  wire tick    = (pre_q == PLAST);
  wire fall    = pin_s[2] & ~pin_s[1];
  wire split   = (mode_q == 2'b11);
  wire en_lo   = run0_q & (~gate_q | gate_s[1]);
  wire lo_step = en_lo & (ct_q ? fall : tick);
  wire hi_step = split & run1_q & tick;
  wire lo_ovf  = lo_step & (&lo_q);
  wire hi_ovf  = hi_step & (&hi_q);
  wire wr_mode = wr_en & (wr_sel == SEL_MODE);
  wire wr_ctrl = wr_en & (wr_sel == SEL_CTRL);
  wire wr_lo   = wr_en & (wr_sel == SEL_LO);
  wire wr_hi   = wr_en & (wr_sel == SEL_HI);

  assign irq_lo = flag_lo;
  assign irq_hi = flag_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      ct_q    <= 1'b0;
      gate_q  <= 1'b0;
      run0_q  <= 1'b0;
      run1_q  <= 1'b0;
      pre_q   <= '0;
      pin_s   <= '0;
      gate_s  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      pre_q  <= tick ? '0 : pre_q + 1'b1;
      pin_s  <= {pin_s[1:0], cnt_pin};
      gate_s <= {gate_s[0], gate_pin};

      if (wr_mode) {gate_q, ct_q, mode_q} <= wr_data[3:0];
      if (wr_ctrl) begin
        run0_q <= wr_data[4];
        run1_q <= wr_data[6];
      end

      if (wr_lo)        lo_q <= wr_data;
      else if (lo_ovf)  lo_q <= split ? '0 : hi_q;
      else if (lo_step) lo_q <= lo_q + 1'b1;

      if (wr_hi)        hi_q <= wr_data;
      else if (hi_step) hi_q <= hi_q + 1'b1;

      if (lo_ovf)      flag_lo <= 1'b1;
      else if (ack_lo) flag_lo <= 1'b0;

      if (hi_ovf)      flag_hi <= 1'b1;
      else if (ack_hi) flag_hi <= 1'b0;
    end
  end
endmodule

module dual8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic         ack_lo,
  input logic         run0_q,
  input logic         tick,
  input logic         lo_step,
  input logic [W-1:0] lo_q,
  input logic [W-1:0] hi_q,
  input logic         flag_lo
);
  p_hi_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && wr_sel == 2'd3)) |=> (hi_q == $past(hi_q)));

  p_stop_r11: assert property (@(posedge clk) disable iff (rst)
    (!run0_q && !(wr_en && wr_sel == 2'd2)) |=> (lo_q == $past(lo_q)));

  p_flag_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_lo) |-> ($past(lo_step) && ($past(lo_q) == '1)));

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_lo && ack_lo && !(lo_step && lo_q == '1)) |=> !flag_lo);

  p_ovf_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (lo_step && lo_q == '1) |=> flag_lo);
endmodule

bind dual8_timer dual8_timer_chk #(.W(W)) u_chk (.*);

// File: tb/dual8_timer_test.sv
module dual8_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_pin = 1'b1, gate_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       ack_lo = 1'b0, ack_hi = 1'b0;
  logic [7:0] lo_q, hi_q;
  logic       flag_lo, flag_hi, irq_lo, irq_hi;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dual8_timer uut (
    .clk(clk), .rst(rst), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_lo(ack_lo), .ack_hi(ack_hi),
    .lo_q(lo_q), .hi_q(hi_q), .flag_lo(flag_lo), .flag_hi(flag_hi),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  // bench model built from the requirements
  logic [1:0] m_mode;
  logic       m_ct, m_gate, m_run0, m_run1, m_f0, m_f1;
  logic [7:0] m_lo, m_hi;
  int         m_p;
  logic [2:0] m_s;
  logic [1:0] m_g;

  function automatic logic [7:0] exp_lo(logic [7:0] lo, logic [7:0] hi, logic step,
                                        logic split, logic wr, logic [7:0] d);
    if (wr) return d;
    if (step && lo == 8'hFF) return split ? 8'h00 : hi;
    if (step) return lo + 8'd1;
    return lo;
  endfunction

  function automatic logic exp_flag(logic f, logic ovf, logic ack);
    if (ovf) return 1'b1;
    if (ack) return 1'b0;
    return f;
  endfunction

  always @(posedge clk) begin : model
    logic tk, fl, sp, e0, s0, s1;
    if (rst) begin
      m_mode = '0; m_ct = 0; m_gate = 0; m_run0 = 0; m_run1 = 0;
      m_f0 = 0; m_f1 = 0; m_lo = '0; m_hi = '0; m_p = 0; m_s = '0; m_g = '0;
    end else begin
      tk = (m_p == 5);
      fl = m_s[2] & ~m_s[1];
      sp = (m_mode == 2'b11);
      e0 = m_run0 & (~m_gate | m_g[1]);
      s0 = e0 & (m_ct ? fl : tk);
      s1 = sp & m_run1 & tk;
      m_f0 = exp_flag(m_f0, s0 && m_lo == 8'hFF, ack_lo);
      m_f1 = exp_flag(m_f1, s1 && m_hi == 8'hFF, ack_hi);
      m_lo = exp_lo(m_lo, m_hi, s0, sp, wr_en && wr_sel == 2'd2, wr_data);
      if (wr_en && wr_sel == 2'd3) m_hi = wr_data;
      else if (s1) m_hi = m_hi + 8'd1;
      if (wr_en && wr_sel == 2'd0) {m_gate, m_ct, m_mode} = wr_data[3:0];
      if (wr_en && wr_sel == 2'd1) begin m_run0 = wr_data[4]; m_run1 = wr_data[6]; end
      m_p = tk ? 0 : m_p + 1;
      m_s = {m_s[1:0], cnt_pin};
      m_g = {m_g[0], gate_pin};
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    check("R3 model lo_q", lo_q, m_lo);
    check("R9 model hi_q", hi_q, m_hi);
    check("R5 model flag_lo", {7'd0, flag_lo}, {7'd0, m_f0});
    check("R5 model flag_hi", {7'd0, flag_hi}, {7'd0, m_f1});
    check("R10 irq_lo", {7'd0, irq_lo}, {7'd0, flag_lo});
    check("R10 irq_hi", {7'd0, irq_hi}, {7'd0, flag_hi});
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'd4242));
    cycn(3);
    rst = 1'b0;
    check("R1 reset lo", lo_q, 8'h00);
    check("R1 reset hi", hi_q, 8'h00);
    check("R1 reset flag_lo", {7'd0, flag_lo}, 8'h00);

    // R11 run bit clear
    wr(0, 8'h00); wr(2, 8'h10); wr(1, 8'h00);
    cycn(30);
    check("R11 held lo", lo_q, 8'h10);

    // R2 divide by six
    wr(1, 8'h10);
    a = lo_q;
    cycn(60);
    check("R2 ten steps in 60", lo_q, a + 8'd10);

    // R3 reload
    wr(1, 8'h00); wr(3, 8'h80); wr(2, 8'hFE); wr(1, 8'h10);
    cycn(12);
    check("R3 reloaded lo", lo_q, 8'h80);
    check("R3 hi unchanged", hi_q, 8'h80);
    check("R3 flag set", {7'd0, flag_lo}, 8'h01);
    check("R10 irq_lo set", {7'd0, irq_lo}, 8'h01);

    // R4 new reload value
    wr(1, 8'h00); wr(3, 8'h33); wr(2, 8'hFF); wr(1, 8'h10);
    cycn(6);
    check("R4 reload 33", lo_q, 8'h33);
    wr(1, 8'h00); wr(3, 8'h55); wr(2, 8'hFF); wr(1, 8'h10);
    cycn(6);
    check("R4 reload 55", lo_q, 8'h55);
    check("R4 hi kept", hi_q, 8'h55);

    // R5 overflow and acknowledge on one edge (flag already set)
    wr(1, 8'h00); wr(2, 8'hFF);
    while (m_p != 4) cyc();
    wr(1, 8'h10);
    ack_lo = 1'b1;
    cyc();
    ack_lo = 1'b0;
    check("R5 ack+ovf keeps flag", {7'd0, flag_lo}, 8'h01);
    check("R5 ack+ovf reload", lo_q, 8'h55);
    wr(1, 8'h00);
    ack_lo = 1'b1; cyc(); ack_lo = 1'b0;
    check("R5 ack clears flag", {7'd0, flag_lo}, 8'h00);

    // R8 write vs reload
    wr(2, 8'hFF);
    while (m_p != 4) cyc();
    wr(1, 8'h10);
    wr(2, 8'h21);
    check("R8 write wins", lo_q, 8'h21);
    check("R8 flag still set", {7'd0, flag_lo}, 8'h01);
    wr(1, 8'h00);
    ack_lo = 1'b1; cyc(); ack_lo = 1'b0;

    // R6 counter source
    wr(0, 8'h04); wr(2, 8'h00); cnt_pin = 1'b1; wr(1, 8'h10);
    cycn(3);
    check("R6 steady pin", lo_q, 8'h00);
    for (int k = 0; k < 5; k++) begin
      cnt_pin = 1'b0; cycn(3);
      cnt_pin = 1'b1; cycn(3);
    end
    check("R6 five falls", lo_q, 8'h05);
    cycn(20);
    check("R6 no clock counting", lo_q, 8'h05);

    // R7 gate
    wr(1, 8'h00); wr(0, 8'h08); gate_pin = 1'b0; wr(2, 8'h40); wr(1, 8'h10);
    cycn(30);
    check("R7 gated hold", lo_q, 8'h40);
    gate_pin = 1'b1;
    cycn(3);
    a = lo_q;
    cycn(60);
    check("R7 gate open counts", lo_q, a + 8'd10);

    // R9 split mode
    wr(1, 8'h00); gate_pin = 1'b0; wr(0, 8'h0F);
    wr(3, 8'hFE); wr(2, 8'hFF); wr(1, 8'h50);
    cycn(12);
    check("R9 hi wrapped", hi_q, 8'h00);
    check("R9 flag_hi", {7'd0, flag_hi}, 8'h01);
    check("R10 irq_hi", {7'd0, irq_hi}, 8'h01);
    check("R9 lo gated", lo_q, 8'hFF);
    wr(0, 8'h03);
    cycn(6);
    check("R9 lo wraps to zero", lo_q, 8'h00);
    check("R9 flag_lo", {7'd0, flag_lo}, 8'h01);
    ack_hi = 1'b1; cyc(); ack_hi = 1'b0;
    check("R5 ack_hi clears", {7'd0, flag_hi}, 8'h00);

    // R1 reset while running
    rst = 1'b1; cyc(); rst = 1'b0;
    check("R1 mid reset lo", lo_q, 8'h00);
    check("R1 mid reset flag_lo", {7'd0, flag_lo}, 8'h00);
    cycn(30);
    check("R1 run cleared", lo_q, 8'h00);

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en   = ($urandom_range(7) == 0);
      wr_sel  = 2'($urandom_range(3));
      wr_data = 8'($urandom_range(255));
      if (wr_en && wr_sel == 2'd2 && $urandom_range(3) != 0) wr_data = 8'hF0 | wr_data;
      ack_lo  = ($urandom_range(7) == 0);
      ack_hi  = ($urandom_range(7) == 0);
      if ($urandom_range(3) == 0) cnt_pin = ~cnt_pin;
      if ($urandom_range(15) == 0) gate_pin = ~gate_pin;
      cyc();
    end
    wr_en = 1'b0; ack_lo = 1'b0; ack_hi = 1'b0;
    cyc();
    finish_run();
  end
endmodule